// File: doc/BRIEF.md
# Accelerator Interrupt Aggregator and Forwarder

This block gathers interrupt events from a group of accelerator cores, from their mailbox channels and from a bridge DMA engine, and turns them into one interrupt toward a PCIe endpoint core. The link behind that endpoint cannot carry the per-core lines, so the block keeps a record of which core fired and why. A host reads that record over a small register port and acknowledges it with write-one-to-clear accesses.

Each core reports an event as a non-zero 2-bit cause. The cause is latched next to a sticky status bit. Mailbox events and bridge DMA events are kept in two further status classes. A mask register decides which sources may drive the combined interrupt. The interrupt is offered both as a level and as a one-cycle message pulse. A source-index register names the lowest-numbered core that is pending, so the handler can reach it without scanning.

Top module: `intr_aggregator`

## Requirements
- R1: A non-zero cause on core i sets core status bit i (address 0, bit i). The bit stays set until a write to address 0 has bit i at one. If an event and that clear arrive in the same cycle, the bit stays set.
- R2: Cause codes are 01 for page fault, 10 for DMA error and 11 for completion. They read back at address 1, bits [2i+1:2i] for core i. A cause is captured when its status bit goes from clear to set, or when an event coincides with the clear of that bit. While the bit stays set otherwise, the cause holds and later causes are ignored. A clear returns the cause to 00.
- R3: A mailbox event on core i sets bit i at address 2. Writing one to that bit clears it, and a coincident event wins.
- R4: A bridge DMA event sets bit 0 at address 3. Writing one to that bit clears it, and a coincident event wins.
- R5: The mask at address 4 is read/write. Bits [N-1:0] cover the cores, bits [2N-1:N] the mailboxes and bit 2N the bridge. A mask bit of one keeps that source from forwarding, but its status still latches.
- R6: irq_level_o is high, one cycle after the state changes, exactly while some status bit is set whose mask bit is zero.
- R7: irq_pulse_o is high for one cycle after every event on an unmasked source. This includes an event on a bit that is already set or is being acknowledged. It is also high when a mask write or an event first makes the unmasked pending set non-empty.
- R8: Address 5 returns the index of the lowest-numbered core whose status bit is set, in the low bits, with bit 8 at one. When no core is pending it returns 0.
- R9: Address 6 returns, in bits 0, 1 and 2, whether any unmasked core, mailbox or bridge status is pending.
- R10: After reset all status, cause and mask state is zero, and so are both interrupt outputs and the read data.
- R11: reg_rdata_o is registered from reg_addr_i and shows the state before the updates of the same clock edge. Addresses 1, 5, 6 and 7 ignore writes, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_cause_i | input | 2*NCORE | Per-core event cause, non-zero marks an event |
| mbox_evt_i | input | NCORE | Per-core mailbox event |
| bdma_evt_i | input | 1 | Bridge DMA engine event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data |
| irq_level_o | output | 1 | Combined interrupt, level form |
| irq_pulse_o | output | 1 | Combined interrupt, message pulse form |

## Verification
The hardest case to reach is a new event landing on the same core in the same cycle as the host's write-one-to-clear of that core. Here the status must survive, the cause must be replaced and the message pulse must fire again even though the level never dropped. Random traffic seldom lines these up, so a directed sequence forces the collision. A second directed sequence latches an event under mask and then lifts the mask, to show that the pulse is driven by the rising pending set. Random events and register writes then run against a cycle-accurate reference model kept in the bench.

// File: rtl/intr_aggr_pkg.sv
package intr_aggr_pkg;
  localparam int A_CORE_ST    = 0;
  localparam int A_CORE_CAUSE = 1;
  localparam int A_MBOX_ST    = 2;
  localparam int A_BDMA_ST    = 3;
  localparam int A_MASK       = 4;
  localparam int A_SRCIDX     = 5;
  localparam int A_CLASS      = 6;
  localparam int IDX_VALID_BIT = 8;
  localparam logic [1:0] CAUSE_NONE   = 2'b00;
  localparam logic [1:0] CAUSE_PGFLT  = 2'b01;
  localparam logic [1:0] CAUSE_DMAERR = 2'b10;
  localparam logic [1:0] CAUSE_DONE   = 2'b11;
endpackage

// File: rtl/intr_sticky.sv
module intr_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_q,
  output logic [W-1:0] st_d
);
  always_comb st_d = (st_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  // R1
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));

  // R1
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(st_q) & ~st_q & ~$past(clr_i)) == '0));
endmodule

// File: rtl/intr_lowest.sv
module intr_lowest #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end

  // R8
  always_comb begin
    if (any_o) lowest_set_chk: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/intr_fwd.sv
module intr_fwd #(
  parameter int N = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_d_i,
  input  logic         hit_i,
  output logic         irq_level_o,
  output logic         irq_pulse_o
);
  logic any_d;
  always_comb any_d = |pend_d_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level_o <= 1'b0;
      irq_pulse_o <= 1'b0;
    end else begin
      irq_level_o <= any_d;
      irq_pulse_o <= hit_i | (any_d & ~irq_level_o);
    end
  end

  // R7
  event_repulse_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> irq_pulse_o);

  // R7
  pulse_has_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse_o |-> irq_level_o);

  // R6
  level_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !any_d |=> !irq_level_o);
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_aggr_pkg::*;
#(
  parameter int NCORE = 8,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*NCORE-1:0] core_cause_i,
  input  logic [NCORE-1:0]   mbox_evt_i,
  input  logic               bdma_evt_i,
  input  logic               reg_wr_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_level_o,
  output logic               irq_pulse_o
);
  localparam int IW   = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int NSRC = 2 * NCORE + 1;

  logic [NCORE-1:0] core_set, core_clr, core_st_q, core_st_d;
  logic [NCORE-1:0] mbox_clr, mbox_st_q, mbox_st_d;
  logic [0:0]       bdma_set, bdma_clr, bdma_st_q, bdma_st_d;
  logic [2*NCORE-1:0] cause_q;
  logic [NSRC-1:0]  mask_q, mask_d, all_set, all_st_d, all_st_q, pend_d, pend_q;
  logic [IW-1:0]    low_idx;
  logic             low_any, hit;
  logic [DW-1:0]    rd_mux;
  logic wr_core, wr_mbox, wr_bdma, wr_mask;

  always_comb begin
    wr_core = reg_wr_i && (reg_addr_i == AW'(A_CORE_ST));
    wr_mbox = reg_wr_i && (reg_addr_i == AW'(A_MBOX_ST));
    wr_bdma = reg_wr_i && (reg_addr_i == AW'(A_BDMA_ST));
    wr_mask = reg_wr_i && (reg_addr_i == AW'(A_MASK));
    core_clr = wr_core ? reg_wdata_i[NCORE-1:0] : '0;
    mbox_clr = wr_mbox ? reg_wdata_i[NCORE-1:0] : '0;
    bdma_clr = wr_bdma ? reg_wdata_i[0:0] : '0;
    bdma_set = bdma_evt_i;
    mask_d   = wr_mask ? reg_wdata_i[NSRC-1:0] : mask_q;
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    always_comb core_set[i] = |core_cause_i[2*i +: 2];

    always_ff @(posedge clk) begin
      if (rst)
        cause_q[2*i +: 2] <= CAUSE_NONE;
      else if (core_set[i] && (!core_st_q[i] || core_clr[i]))
        cause_q[2*i +: 2] <= core_cause_i[2*i +: 2];
      else if (core_clr[i])
        cause_q[2*i +: 2] <= CAUSE_NONE;
    end

    // R2
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(core_st_q[i]) && !$past(core_clr[i])) |-> $stable(cause_q[2*i +: 2]));

    // R2
    cause_present_chk: assert property (@(posedge clk) disable iff (rst)
      core_st_q[i] |-> (cause_q[2*i +: 2] != CAUSE_NONE));
  end

  intr_sticky #(.W(NCORE)) u_core_st (
    .clk(clk), .rst(rst), .set_i(core_set), .clr_i(core_clr),
    .st_q(core_st_q), .st_d(core_st_d));

  intr_sticky #(.W(NCORE)) u_mbox_st (
    .clk(clk), .rst(rst), .set_i(mbox_evt_i), .clr_i(mbox_clr),
    .st_q(mbox_st_q), .st_d(mbox_st_d));

  intr_sticky #(.W(1)) u_bdma_st (
    .clk(clk), .rst(rst), .set_i(bdma_set), .clr_i(bdma_clr),
    .st_q(bdma_st_q), .st_d(bdma_st_d));

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  always_comb begin
    all_set  = {bdma_set, mbox_evt_i, core_set};
    all_st_d = {bdma_st_d, mbox_st_d, core_st_d};
    all_st_q = {bdma_st_q, mbox_st_q, core_st_q};
    pend_d   = all_st_d & ~mask_d;
    pend_q   = all_st_q & ~mask_q;
    hit      = |(all_set & ~mask_d);
  end

  intr_lowest #(.N(NCORE), .IW(IW)) u_lowest (
    .req_i(core_st_q), .idx_o(low_idx), .any_o(low_any));

  intr_fwd #(.N(NSRC)) u_fwd (
    .clk(clk), .rst(rst), .pend_d_i(pend_d), .hit_i(hit),
    .irq_level_o(irq_level_o), .irq_pulse_o(irq_pulse_o));

  always_comb begin
    rd_mux = '0;
    case (int'(reg_addr_i))
      A_CORE_ST:    rd_mux[NCORE-1:0]   = core_st_q;
      A_CORE_CAUSE: rd_mux[2*NCORE-1:0] = cause_q;
      A_MBOX_ST:    rd_mux[NCORE-1:0]   = mbox_st_q;
      A_BDMA_ST:    rd_mux[0]           = bdma_st_q[0];
      A_MASK:       rd_mux[NSRC-1:0]    = mask_q;
      A_SRCIDX: begin
        if (low_any) begin
          rd_mux[IW-1:0]        = low_idx;
          rd_mux[IDX_VALID_BIT] = 1'b1;
        end
      end
      A_CLASS: begin
        rd_mux[0] = |pend_q[NCORE-1:0];
        rd_mux[1] = |pend_q[2*NCORE-1:NCORE];
        rd_mux[2] = pend_q[NSRC-1];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_mux;
  end

  // R5
  masked_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|(core_set & mask_d[NCORE-1:0])) |=> ((core_st_q & $past(core_set)) == $past(core_set)));
endmodule

// File: tb/test_intr_aggregator.sv
module test_intr_aggregator;
  import intr_aggr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*N-1:0] core_cause;
  logic [N-1:0]   mbox_evt;
  logic           bdma_evt;
  logic           reg_wr;
  logic [2:0]     reg_addr;
  logic [31:0]    reg_wdata;
  logic [31:0]    reg_rdata;
  logic           irq_level, irq_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [N-1:0]   m_core, m_mbox;
  logic           m_bdma;
  logic [2*N-1:0] m_cause;
  logic [2*N:0]   m_mask;
  logic           m_level, m_pulse;
  logic [31:0]    m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_aggregator #(.NCORE(N), .AW(3), .DW(32)) i_intr_aggregator (
    .clk(clk), .rst(rst), .core_cause_i(core_cause), .mbox_evt_i(mbox_evt),
    .bdma_evt_i(bdma_evt), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_level_o(irq_level), .irq_pulse_o(irq_pulse));

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] read_val(input logic [2:0] a);
    logic [31:0] v;
    logic [2*N:0] pq;
    v = '0;
    pq = {m_bdma, m_mbox, m_core} & ~m_mask;
    case (a)
      3'd0: v[N-1:0] = m_core;
      3'd1: v[2*N-1:0] = m_cause;
      3'd2: v[N-1:0] = m_mbox;
      3'd3: v[0] = m_bdma;
      3'd4: v[2*N:0] = m_mask;
      3'd5: begin
        for (int i = N - 1; i >= 0; i--)
          if (m_core[i]) v = 32'(i) | (32'd1 << IDX_VALID_BIT);
      end
      3'd6: v[2:0] = {pq[2*N], |pq[2*N-1:N], |pq[N-1:0]};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2*N-1:0] cc, input logic [N-1:0] mb, input logic bd,
                      input logic wr, input logic [2:0] a, input logic [31:0] wd);
    logic [N-1:0] cset, cclr, mclr, nc, nm;
    logic bclr, nb;
    logic [2*N-1:0] ncause;
    logic [2*N:0] nmask, pend, allset;
    core_cause = cc; mbox_evt = mb; bdma_evt = bd;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    m_rdata = read_val(a);
    for (int i = 0; i < N; i++) cset[i] = |cc[2*i +: 2];
    cclr = (wr && a == 3'd0) ? wd[N-1:0] : '0;
    mclr = (wr && a == 3'd2) ? wd[N-1:0] : '0;
    bclr = wr && a == 3'd3 && wd[0];
    nc = (m_core & ~cclr) | cset;
    nm = (m_mbox & ~mclr) | mb;
    nb = (m_bdma & ~bclr) | bd;
    ncause = m_cause;
    for (int i = 0; i < N; i++) begin
      if (cset[i] && (!m_core[i] || cclr[i])) ncause[2*i +: 2] = cc[2*i +: 2];
      else if (cclr[i]) ncause[2*i +: 2] = CAUSE_NONE;
    end
    nmask = (wr && a == 3'd4) ? wd[2*N:0] : m_mask;
    pend = {nb, nm, nc} & ~nmask;
    allset = {bd, mb, cset};
    m_pulse = (|(allset & ~nmask)) | ((|pend) & ~m_level);
    m_level = |pend;
    m_core = nc; m_mbox = nm; m_bdma = nb; m_cause = ncause; m_mask = nmask;
    @(posedge clk);
    @(negedge clk);
    check("R6", 32'(irq_level), 32'(m_level));
    check("R7", 32'(irq_pulse), 32'(m_pulse));
    check(tag_of(a), reg_rdata, m_rdata);
  endtask

  task automatic idle_rd(input logic [2:0] a);
    step('0, '0, 1'b0, 1'b0, a, '0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    core_cause = '0; mbox_evt = '0; bdma_evt = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_core = '0; m_mbox = '0; m_bdma = 1'b0; m_cause = '0; m_mask = '0;
    m_level = 1'b0; m_pulse = 1'b0; m_rdata = '0;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10", 32'(irq_level), 32'd0);
    check("R10", 32'(irq_pulse), 32'd0);
    check("R10", reg_rdata, 32'd0);
    for (int a = 0; a < 8; a++) idle_rd(3'(a));

    // R1 R2: core 3 page fault, then a later cause is ignored
    step(16'(CAUSE_PGFLT) << 6, '0, 1'b0, 1'b0, 3'd1, '0);
    idle_rd(3'd1);
    step(16'(CAUSE_DMAERR) << 6, '0, 1'b0, 1'b0, 3'd1, '0);
    idle_rd(3'd1);
    idle_rd(3'd5);
    // R1 R7: event collides with clear on core 3, status survives, cause replaced
    step(16'(CAUSE_DONE) << 6, '0, 1'b0, 1'b1, 3'd0, 32'h8);
    idle_rd(3'd0);
    idle_rd(3'd1);
    step('0, '0, 1'b0, 1'b1, 3'd0, 32'h8);
    idle_rd(3'd0);
    // R5: masked core 5 latches silently, then unmask raises a pulse
    step('0, '0, 1'b0, 1'b1, 3'd4, 32'h20);
    step(16'(CAUSE_DMAERR) << 10, '0, 1'b0, 1'b0, 3'd0, '0);
    idle_rd(3'd6);
    step('0, '0, 1'b0, 1'b1, 3'd4, 32'h0);
    idle_rd(3'd6);
    // R8: lowest index with cores 7 and 2 pending
    step((16'(CAUSE_DONE) << 14) | (16'(CAUSE_PGFLT) << 4), '0, 1'b0, 1'b0, 3'd5, '0);
    idle_rd(3'd5);
    step('0, '0, 1'b0, 1'b1, 3'd0, 32'hFF);
    idle_rd(3'd5);
    // R3 R4 R9: mailbox and bridge classes
    step('0, 8'h81, 1'b1, 1'b0, 3'd2, '0);
    idle_rd(3'd2);
    idle_rd(3'd3);
    idle_rd(3'd6);
    step('0, 8'h01, 1'b1, 1'b1, 3'd2, 32'h81);
    step('0, '0, 1'b0, 1'b1, 3'd3, 32'h1);
    idle_rd(3'd3);
    // R11: writes to read-only addresses are ignored
    step('0, '0, 1'b0, 1'b1, 3'd1, 32'hFFFF_FFFF);
    step('0, '0, 1'b0, 1'b1, 3'd7, 32'hFFFF_FFFF);
    idle_rd(3'd7);

    // constrained random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [2*N-1:0] cc;
      logic [N-1:0] mb;
      logic [31:0] wd;
      cc = '0;
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 9) == 0) cc[2*i +: 2] = 2'($urandom_range(1, 3));
      mb = ($urandom_range(0, 5) == 0) ? 8'(1 << $urandom_range(0, N-1)) : '0;
      wd = $urandom;
      step(cc, mb, ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) == 0),
           3'($urandom_range(0, 7)), wd);
    end
    finish_run();
  end
endmodule